// File: doc/BRIEF.md
# Mode-Selectable Timeout Down-Counter

This block supervises a bus controller with a 16-bit down-counter. Software programs a start period, an enable bit and a source select through a small register write port. The counter counts down on an external tick. It then either runs freely, or it watches one of three FIFOs: a transmit event FIFO or one of two receive FIFOs. When the count reaches zero, a sticky timeout flag is raised.

In free-running mode, software restarts the countdown by writing to the count address. In a FIFO mode the selected FIFO controls the counter. An empty FIFO keeps the counter parked at the period. A store into that FIFO starts the countdown, so the timeout marks data left unserviced for too long. The configuration can only be changed while both the configuration-change-enable input and the init input are high.

A combinational read port returns the configuration, the current count or the flag.

Top module: `tmo_counter`

## Requirements
- R1: After reset the configuration reads 0xFFFF0000 (period all ones, free-running mode, disabled), the count is 0xFFFF and the timeout flag is 0.
- R2: A write to address 0 takes effect only when `cfg_chg_en_i` and `init_i` are both high; any other write to address 0 leaves the configuration unchanged. An accepted write loads the new period into the counter and stops any FIFO-started countdown.
- R3: Configuration field layout: period in bits 31:16, source select in bits 2:1 and enable in bit 0. Select codes: 0 = free-running; 1 = transmit event FIFO (index 0 of the FIFO vectors); 2 = receive FIFO A (index 1); 3 = receive FIFO B (index 2).
- R4: While counting is active, each cycle with `tick_i` high lowers the count by exactly one. In free-running mode, counting is always active when the block is enabled.
- R5: In free-running mode, a write to address 1 reloads the count with the period. If a tick arrives in the same cycle, the reload wins.
- R6: In a FIFO mode, a cycle in which the selected FIFO is empty (with no store) presets the count to the period and stops counting.
- R7: In a FIFO mode, a store into the selected FIFO starts counting. The first decrement happens on a tick after the store cycle. Further stores do not reload the count.
- R8: When the selected FIFO signals empty and store in the same cycle, the store wins.
- R9: In a FIFO mode, empty and store events from FIFOs that are not selected have no effect, and neither do writes to address 1.
- R10: While the enable bit is 0, the count equals the period, ticks are ignored and the flag is never set.
- R11: The counter stops at zero. The flag rises on the same clock edge at which a decrement takes the count from 1 to 0.
- R12: The flag stays set until a write to address 2 with data bit 0 high clears it. A write with bit 0 low leaves it set. If a new timeout coincides with the clear, the flag stays set.
- R13: Read map by address: 0 returns the configuration; 1 returns the count in bits 15:0 with zeros above; 2 returns the flag in bit 0; 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count tick, one decrement per high cycle |
| fifo_empty_i | input | 3 | Empty indication per FIFO (0 transmit event, 1 receive A, 2 receive B) |
| fifo_store_i | input | 3 | Element-stored strobe per FIFO |
| cfg_chg_en_i | input | 1 | Configuration change enable |
| init_i | input | 1 | Controller init state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| count_o | output | 16 | Current count |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
Directed sequences cover the distinctions that random traffic rarely produces:
- a locked write against an accepted one;
- a reload and a tick in the same cycle;
- empty and store from the selected FIFO in the same cycle;
- events on the FIFOs that are not selected;
- a flag clear written with bit 0 low.

Random traffic then mixes ticks, FIFO strobes, every select code, small periods and gated writes. This shows whether counting, stopping at zero and preset order stay correct across mode changes and when the period is zero. Every cycle compares the count, the flag and the read port against a reference model built from the requirements.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int CNT_W      = 16;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2;
    localparam int NUM_SRC    = 3;
    localparam int SEL_W      = 2;
    localparam int PERIOD_LSB = DATA_W - CNT_W;
    localparam int SEL_LSB    = 1;
    localparam int EN_BIT     = 0;

    localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;

    typedef enum logic [SEL_W-1:0] {
        SRC_FREE = 2'd0,
        SRC_TXEV = 2'd1,
        SRC_RXA  = 2'd2,
        SRC_RXB  = 2'd3
    } tmo_src_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        tmo_src_e         src;
        logic             enable;
    } tmo_cfg_t;

    localparam tmo_cfg_t CFG_RESET = '{period: '1, src: SRC_FREE, enable: 1'b0};
endpackage

// File: rtl/tmo_cfg_regs.sv
module tmo_cfg_regs
    import tmo_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [CNT_W-1:0]     wr_period_i,
    input  logic [SEL_W-1:0]     wr_src_i,
    input  logic                 wr_enable_i,
    input  logic                 cfg_chg_en_i,
    input  logic                 init_i,
    output tmo_cfg_t             cfg_o,
    output tmo_cfg_t             cfg_next_o,
    output logic                 cfg_wr_o
);
    typedef struct packed {
        tmo_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_en_i && (wr_addr_i == ADR_CFG) && cfg_chg_en_i && init_i;
        if (accept) begin
            st_d.cfg.period = wr_period_i;
            st_d.cfg.src    = tmo_src_e'(wr_src_i);
            st_d.cfg.enable = wr_enable_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o      = st_q.cfg;
    assign cfg_next_o = st_d.cfg;
    assign cfg_wr_o   = accept;
endmodule

// File: rtl/tmo_event_sel.sv
module tmo_event_sel
    import tmo_pkg::*;
(
    input  tmo_src_e             src_i,
    input  logic [NUM_SRC-1:0]   fifo_empty_i,
    input  logic [NUM_SRC-1:0]   fifo_store_i,
    output logic                 fifo_mode_o,
    output logic                 sel_empty_o,
    output logic                 sel_store_o
);
    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
        assign hit[g] = (src_i == tmo_src_e'(SEL_W'(g + 1)));
    end

    assign fifo_mode_o = |hit;
    assign sel_empty_o = |(hit & fifo_empty_i);
    assign sel_store_o = |(hit & fifo_store_i);
endmodule

// File: rtl/tmo_count_core.sv
module tmo_count_core
    import tmo_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tmo_cfg_t         cfg_i,
    input  tmo_cfg_t         cfg_next_i,
    input  logic             cfg_wr_i,
    input  logic             cnt_wr_i,
    input  logic             flag_clr_i,
    input  logic             tick_i,
    input  logic             fifo_mode_i,
    input  logic             sel_empty_i,
    input  logic             sel_store_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             flag;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        step;
    logic        hit_zero;
    logic        nonzero;

    always_comb begin
        st_d     = st_q;
        step     = 1'b0;
        nonzero  = (st_q.count != '0);
        if (cfg_wr_i) begin
            st_d.count   = cfg_next_i.period;
            st_d.running = 1'b0;
        end else if (!cfg_i.enable) begin
            st_d.count   = cfg_i.period;
            st_d.running = 1'b0;
        end else if (!fifo_mode_i) begin
            if (cnt_wr_i) begin
                st_d.count = cfg_i.period;
            end else begin
                step = tick_i && nonzero;
            end
        end else if (sel_store_i) begin
            st_d.running = 1'b1;
            step         = st_q.running && tick_i && nonzero;
        end else if (sel_empty_i) begin
            st_d.count   = cfg_i.period;
            st_d.running = 1'b0;
        end else begin
            step = st_q.running && tick_i && nonzero;
        end

        if (step) begin
            st_d.count = st_q.count - 1'b1;
        end
        hit_zero = step && (st_q.count == CNT_W'(1));

        if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
        if (hit_zero) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.count   <= CFG_RESET.period;
            st_q.running <= 1'b0;
            st_q.flag    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign flag_o  = st_q.flag;
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
    import tmo_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic [2:0]          fifo_empty_i,
    input  logic [2:0]          fifo_store_i,
    input  logic                cfg_chg_en_i,
    input  logic                init_i,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [31:0]         wr_data_i,
    input  logic [1:0]          rd_addr_i,
    output logic [31:0]         rd_data_o,
    output logic [15:0]         count_o,
    output logic                timeout_o
);
    tmo_cfg_t         cfg_cur;
    tmo_cfg_t         cfg_nxt;
    logic             cfg_wr;
    logic             fifo_mode;
    logic             sel_empty;
    logic             sel_store;
    logic             cnt_wr;
    logic             flag_clr;
    logic [CNT_W-1:0] count;
    logic             flag;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i[PERIOD_LSB-1:SEL_LSB+SEL_W];

    assign cnt_wr   = wr_en_i && (wr_addr_i == ADR_CNT);
    assign flag_clr = wr_en_i && (wr_addr_i == ADR_FLAG) && wr_data_i[0];

    tmo_cfg_regs u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_period_i  (wr_data_i[DATA_W-1:PERIOD_LSB]),
        .wr_src_i     (wr_data_i[SEL_LSB+SEL_W-1:SEL_LSB]),
        .wr_enable_i  (wr_data_i[EN_BIT]),
        .cfg_chg_en_i (cfg_chg_en_i),
        .init_i       (init_i),
        .cfg_o        (cfg_cur),
        .cfg_next_o   (cfg_nxt),
        .cfg_wr_o     (cfg_wr)
    );

    tmo_event_sel u_sel (
        .src_i        (cfg_cur.src),
        .fifo_empty_i (fifo_empty_i),
        .fifo_store_i (fifo_store_i),
        .fifo_mode_o  (fifo_mode),
        .sel_empty_o  (sel_empty),
        .sel_store_o  (sel_store)
    );

    tmo_count_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_i       (cfg_cur),
        .cfg_next_i  (cfg_nxt),
        .cfg_wr_i    (cfg_wr),
        .cnt_wr_i    (cnt_wr),
        .flag_clr_i  (flag_clr),
        .tick_i      (tick_i),
        .fifo_mode_i (fifo_mode),
        .sel_empty_i (sel_empty),
        .sel_store_i (sel_store),
        .count_o     (count),
        .flag_o      (flag)
    );

    // R13 read map
    always_comb begin
        unique case (rd_addr_i)
            ADR_CFG:  rd_data_o = {cfg_cur.period, {(PERIOD_LSB-SEL_W-1){1'b0}},
                                   cfg_cur.src, cfg_cur.enable};
            ADR_CNT:  rd_data_o = {{(DATA_W-CNT_W){1'b0}}, count};
            ADR_FLAG: rd_data_o = {{(DATA_W-1){1'b0}}, flag};
            default:  rd_data_o = '0;
        endcase
    end

    assign count_o   = count;
    assign timeout_o = flag;
endmodule

// File: rtl/tmo_counter_chk.sv
module tmo_counter_chk
    import tmo_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic [2:0]        fifo_empty_i,
    input logic [2:0]        fifo_store_i,
    input logic              cfg_chg_en_i,
    input logic              init_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic              wr_bit0_i,
    input logic [15:0]       count_o,
    input logic              timeout_o,
    input tmo_cfg_t          cfg_cur
);
    logic cfg_ok;
    logic chk_empty;
    logic chk_store;
    logic clr_req;

    assign cfg_ok  = wr_en_i && (wr_addr_i == ADR_CFG) && cfg_chg_en_i && init_i;
    assign clr_req = wr_en_i && (wr_addr_i == ADR_FLAG) && wr_bit0_i;

    always_comb begin
        chk_empty = 1'b0;
        chk_store = 1'b0;
        case (cfg_cur.src)
            SRC_TXEV: begin chk_empty = fifo_empty_i[0]; chk_store = fifo_store_i[0]; end
            SRC_RXA:  begin chk_empty = fifo_empty_i[1]; chk_store = fifo_store_i[1]; end
            SRC_RXB:  begin chk_empty = fifo_empty_i[2]; chk_store = fifo_store_i[2]; end
            default:  ;
        endcase
    end

    p_cfg_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADR_CFG && !(cfg_chg_en_i && init_i))
        |=> (cfg_cur == $past(cfg_cur)));

    p_dec_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_cur.enable && cfg_cur.src == SRC_FREE && !wr_en_i && tick_i && count_o != '0)
        |=> (count_o == $past(count_o) - 16'd1));

    p_empty_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_cur.enable && cfg_cur.src != SRC_FREE && chk_empty && !chk_store && !cfg_ok)
        |=> (count_o == cfg_cur.period));

    p_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_cur.enable |-> (count_o == cfg_cur.period));

    p_zero_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == '0 && !wr_en_i && fifo_empty_i == '0) |=> (count_o == '0));

    p_flag_on_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o != '0 && !wr_en_i && fifo_empty_i == '0) |=> (count_o != '0 || timeout_o));

    p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o && !clr_req) |=> timeout_o);
endmodule

bind tmo_counter tmo_counter_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_store_i (fifo_store_i),
    .cfg_chg_en_i (cfg_chg_en_i),
    .init_i       (init_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_bit0_i    (wr_data_i[0]),
    .count_o      (count_o),
    .timeout_o    (timeout_o),
    .cfg_cur      (cfg_cur)
);

// File: tb/tmo_counter_tb_top.sv
module tmo_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  f_empty = '0;
    logic [2:0]  f_store = '0;
    logic        cce = 1'b0;
    logic        init = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] count;
    logic        timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_period = 16'hFFFF;
    logic [1:0]  m_src = 2'd0;
    logic        m_en = 1'b0;
    logic [15:0] m_count = 16'hFFFF;
    logic        m_run = 1'b0;
    logic        m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmo_counter dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .fifo_empty_i (f_empty),
        .fifo_store_i (f_store),
        .cfg_chg_en_i (cce),
        .init_i       (init),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .count_o      (count),
        .timeout_o    (timeout)
    );

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {m_period, 13'd0, m_src, m_en};
            2'd1:    return {16'd0, m_count};
            2'd2:    return {31'd0, m_flag};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // reference model step from the requirements
    task automatic model_step();
        logic [15:0] n_count = m_count;
        logic        n_run = m_run;
        logic        set = 1'b0;
        logic        dec = 1'b0;
        logic        se = 1'b0;
        logic        ss = 1'b0;
        logic [15:0] n_period = m_period;
        logic [1:0]  n_src = m_src;
        logic        n_en = m_en;
        if (m_src != 2'd0) begin
            se = f_empty[m_src - 2'd1];
            ss = f_store[m_src - 2'd1];
        end
        if (wr_en && wr_addr == 2'd0 && cce && init) begin
            n_period = wr_data[31:16];
            n_src    = wr_data[2:1];
            n_en     = wr_data[0];
            n_count  = wr_data[31:16];
            n_run    = 1'b0;
        end else if (!m_en) begin
            n_count = m_period;
            n_run   = 1'b0;
        end else if (m_src == 2'd0) begin
            if (wr_en && wr_addr == 2'd1) n_count = m_period;
            else dec = tick && (m_count != 0);
        end else if (ss) begin
            n_run = 1'b1;
            dec   = m_run && tick && (m_count != 0);
        end else if (se) begin
            n_count = m_period;
            n_run   = 1'b0;
        end else begin
            dec = m_run && tick && (m_count != 0);
        end
        if (dec) begin
            n_count = m_count - 16'd1;
            set     = (m_count == 16'd1);
        end
        m_flag   = (m_flag && !(wr_en && wr_addr == 2'd2 && wr_data[0])) || set;
        m_period = n_period;
        m_src    = n_src;
        m_en     = n_en;
        m_count  = n_count;
        m_run    = n_run;
    endtask

    task automatic compare(input string tag);
        chk(count == m_count, {tag, " count"}, {16'd0, count}, {16'd0, m_count});
        chk(timeout == m_flag, {tag, " flag"}, {31'd0, timeout}, {31'd0, m_flag});
        chk(rd_data == exp_rd(rd_addr), {tag, " read"}, rd_data, exp_rd(rd_addr));
    endtask

    // one clock: model uses inputs present at the edge, outputs checked at negedge
    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        tick = 0; f_empty = '0; f_store = '0; wr_en = 0; wr_addr = 0; wr_data = 0;
    endtask

    task automatic wr_cfg(input logic [15:0] per, input logic [1:0] src, input logic en, input string tag);
        idle(); cce = 1; init = 1;
        wr_en = 1; wr_addr = 2'd0; wr_data = {per, 13'd0, src, en};
        cyc(tag);
        idle();
    endtask

    task automatic ticks(input int n, input string tag);
        idle(); tick = 1;
        for (int i = 0; i < n; i++) cyc(tag);
        idle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, MAX_CYCLES);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd_addr = 2'd0;
        #1;
        chk(rd_data == 32'hFFFF0000, "R1 cfg", rd_data, 32'hFFFF0000);
        chk(count == 16'hFFFF, "R1 count", {16'd0, count}, 32'h0000FFFF);
        chk(timeout == 1'b0, "R1 flag", {31'd0, timeout}, 32'd0);

        // R2 locked write ignored
        idle(); cce = 1; init = 0; wr_en = 1; wr_addr = 0; wr_data = {16'd5, 13'd0, 2'd0, 1'b1};
        cyc("R2 locked init");
        cce = 0; init = 1;
        cyc("R2 locked cce");
        idle();
        chk(rd_data == 32'hFFFF0000, "R2 cfg unchanged", rd_data, 32'hFFFF0000);

        // R3 accepted write, field layout
        wr_cfg(16'd5, 2'd0, 1'b1, "R3 write");
        chk(rd_data == 32'h00050001, "R3 layout", rd_data, 32'h00050001);
        rd_addr = 2'd1;
        ticks(3, "R4 decrement");
        chk(count == 16'd2, "R4 count", {16'd0, count}, 32'd2);

        // R5 reload wins over tick
        idle(); tick = 1; wr_en = 1; wr_addr = 2'd1; wr_data = 32'h0;
        cyc("R5 reload");
        idle();
        chk(count == 16'd5, "R5 count", {16'd0, count}, 32'd5);

        // R11 stop at zero, flag
        ticks(5, "R11 to zero");
        chk(timeout == 1'b1, "R11 flag", {31'd0, timeout}, 32'd1);
        ticks(3, "R11 stay zero");
        chk(count == 16'd0, "R11 count", {16'd0, count}, 32'd0);

        // R12 flag clear
        rd_addr = 2'd2;
        idle(); wr_en = 1; wr_addr = 2'd2; wr_data = 32'h0;
        cyc("R12 clear bit0 low");
        chk(timeout == 1'b1, "R12 kept", {31'd0, timeout}, 32'd1);
        wr_data = 32'h1;
        cyc("R12 clear");
        idle();
        chk(timeout == 1'b0, "R12 cleared", {31'd0, timeout}, 32'd0);

        // R10 disabled
        wr_cfg(16'd7, 2'd0, 1'b0, "R10 write");
        ticks(4, "R10 ticks");
        chk(count == 16'd7, "R10 count", {16'd0, count}, 32'd7);

        // FIFO mode on receive A (code 2, index 1)
        rd_addr = 2'd1;
        wr_cfg(16'd4, 2'd2, 1'b1, "R3 fifo cfg");
        idle(); tick = 1; f_empty = 3'b010;
        cyc("R6 empty hold");
        chk(count == 16'd4, "R6 count", {16'd0, count}, 32'd4);
        f_empty = 3'b101; f_store = 3'b101;
        cyc("R9 other fifos");
        cyc("R9 other fifos");
        chk(count == 16'd4, "R9 count", {16'd0, count}, 32'd4);
        f_empty = 3'b010; f_store = 3'b010;
        cyc("R8 store wins");
        f_empty = '0; f_store = '0;
        cyc("R7 count");
        cyc("R7 count");
        chk(count == 16'd2, "R7 count", {16'd0, count}, 32'd2);
        f_store = 3'b010;
        cyc("R7 second store");
        f_store = '0;
        chk(count == 16'd1, "R7 no reload", {16'd0, count}, 32'd1);
        idle(); wr_en = 1; wr_addr = 2'd1;
        cyc("R9 value write ignored");
        chk(count == 16'd1, "R9 write", {16'd0, count}, 32'd1);
        idle(); f_empty = 3'b010;
        cyc("R6 preset");
        chk(count == 16'd4, "R6 preset", {16'd0, count}, 32'd4);
        idle(); f_store = 3'b010;
        cyc("R7 start");
        ticks(4, "R7 run out");
        chk(timeout == 1'b1, "R11 fifo flag", {31'd0, timeout}, 32'd1);
        rd_addr = 2'd3;
        #1;
        chk(rd_data == 32'd0, "R13 unused addr", rd_data, 32'd0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            tick    = ($urandom_range(0, 9) < 6);
            f_empty = 3'(($urandom_range(0, 9) == 0) | (($urandom_range(0, 9) == 0) << 1) | (($urandom_range(0, 9) == 0) << 2));
            f_store = 3'($urandom_range(0, 7) & $urandom_range(0, 7) & $urandom_range(0, 7));
            cce     = ($urandom_range(0, 9) != 0);
            init    = ($urandom_range(0, 9) != 0);
            wr_en   = ($urandom_range(0, 11) == 0);
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = {16'($urandom_range(0, 12)), 13'($urandom), 2'($urandom_range(0, 3)),
                       1'($urandom_range(0, 9) != 0)};
            rd_addr = 2'($urandom_range(0, 3));
            cyc("R4 R6 R7 random");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule